// File: doc/BRIEF.md
# Address-Watch Sleep and Wakeup Unit

This unit parks idle cores on a watched cache line and releases them when that line is written. A core that runs a sleep instruction with an address raises its request line with the address beside it. The unit records the address in that core's reservation slot and holds the core's shutdown output high. The core stays down until the coherence fabric reports an invalidation of the same cache line. That invalidation comes from some other core storing to the line, for example the last thread to reach a barrier flipping the sense word.

Every slot compares its own reservation with the broadcast invalidation in parallel. One invalidation therefore releases every core parked on that line in the same cycle. Each released core gets a one-cycle wakeup pulse, and its reservation is dropped. Only whole cache lines are compared: the low line-offset bits of both addresses are ignored. An invalidation of any other line leaves the reservations alone. If a sleep request and a matching invalidation arrive in the same cycle, the core is not parked. It gets its wakeup pulse straight away, so every accepted sleep request ends in exactly one wakeup.

Top module: `addr_watch_sleep`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `core_sleep` and `wakeup` all zero.
- R2: A `sleep_req` bit on a core whose `core_sleep` is low, with no same-line invalidation in that cycle, sets that core's `core_sleep` from the next cycle on and records the core's address from `sleep_addr`. Core i's address is bits [i*ADDR_W +: ADDR_W] of `sleep_addr`.
- R3: An `inv_valid` cycle whose `inv_addr` lies in the recorded line of a parked core clears that core's `core_sleep` in the next cycle and raises its `wakeup` in that same cycle.
- R4: One matching invalidation releases every core parked on that line in the same cycle. Cores parked on other lines stay parked.
- R5: An invalidation of a different line leaves a parked core's `core_sleep` high and its recorded address unchanged. A later invalidation of the original line still releases the core.
- R6: Lines are compared on address bits [ADDR_W-1:LINE_OFF_W] only. Addresses that differ only below bit LINE_OFF_W (6 by default) match. Addresses that differ at bit LINE_OFF_W do not match.
- R7: A `sleep_req` on an idle core in the same cycle as an invalidation of the requested line does not park the core: its `core_sleep` stays low, and its `wakeup` pulses in the next cycle.
- R8: A `sleep_req` on a core that is already parked is ignored: the original recorded line is kept, and the new address neither parks nor wakes the core.
- R9: `wakeup` lasts exactly one cycle per release. It never rises in a cycle after which no invalidation was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_req | input | NUM_CORES | Per-core sleep instruction request, one cycle |
| sleep_addr | input | NUM_CORES*ADDR_W | Per-core watched address, core i in slice i |
| inv_valid | input | 1 | Coherence invalidation broadcast valid |
| inv_addr | input | ADDR_W | Address of the invalidated line |
| core_sleep | output | NUM_CORES | High while the core is parked and powered down |
| wakeup | output | NUM_CORES | One-cycle release pulse per core |

## Verification
A slot whose stored line or park flag is wrong shows up at the ports within one cycle of the next invalidation that touches it. A lost reservation drops `core_sleep` early. A corrupted line lets the core sleep through its release, or wakes it on a foreign line. The bench keeps a behavioural model of every slot and compares both outputs of every core on every clock. Directed sequences aim at offset-bit aliasing, neighbouring lines, same-cycle aborts and repeated requests on parked cores. A random phase over a small pool of lines makes sharing and collisions frequent. Any divergence is reported in the cycle it first appears.

// File: rtl/awsu_pkg.sv
// Package: shared types of the address-watch sleep unit.
// Assumes: nothing beyond IEEE 1800-2017.
package awsu_pkg;

    // Park state of one reservation slot.
    typedef enum logic {
        SLOT_AWAKE  = 1'b0,
        SLOT_PARKED = 1'b1
    } slot_state_e;

endpackage

// File: rtl/awsu_line_cmp.sv
// Module: awsu_line_cmp
// Says whether two byte addresses fall in the same cache line.
// Assumes: OFF_W < ADDR_W; offset bits are the low OFF_W bits.
module awsu_line_cmp #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same_line
);

    logic [ADDR_W-1:0] diff;

    // Bitwise difference, then discard offset bits by shifting them out.
    always_comb begin
        diff      = addr_a ^ addr_b;
        same_line = ((diff >> OFF_W) == '0);
    end

endmodule

// File: rtl/awsu_slot.sv
// Module: awsu_slot
// One core's reservation: records the watched address on a sleep request,
// holds the core parked, and releases it on a same-line invalidation.
// Assumes: requests arriving while parked are ignored; reset is synchronous.
module awsu_slot
    import awsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic [ADDR_W-1:0] sleep_addr,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              parked,
    output logic              wake_pulse
);

    slot_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wake_q;
    logic              hit_stored;
    logic              hit_request;
    logic              release_now;
    logic              abort_now;
    logic              accept_now;

    // Compare the recorded line with the invalidation.
    awsu_line_cmp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_cmp_stored (
        .addr_a    (addr_q),
        .addr_b    (inv_addr),
        .same_line (hit_stored)
    );

    // Compare the incoming request line with the invalidation.
    awsu_line_cmp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_cmp_request (
        .addr_a    (sleep_addr),
        .addr_b    (inv_addr),
        .same_line (hit_request)
    );

    // Decide this cycle's event: release, abort or accept.
    always_comb begin
        release_now = (state_q == SLOT_PARKED) && inv_valid && hit_stored;
        abort_now   = (state_q == SLOT_AWAKE) && sleep_req && inv_valid && hit_request;
        accept_now  = (state_q == SLOT_AWAKE) && sleep_req && !abort_now;
    end

    // Park state and wakeup pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_AWAKE;
            wake_q  <= 1'b0;
        end else begin
            wake_q <= release_now || abort_now;
            if (release_now) begin
                state_q <= SLOT_AWAKE;
            end else if (accept_now) begin
                state_q <= SLOT_PARKED;
            end
        end
    end

    // Recorded address, loaded only when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept_now) begin
            addr_q <= sleep_addr;
        end
    end

    assign parked     = (state_q == SLOT_PARKED);
    assign wake_pulse = wake_q;

    // R2
    park_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!parked && sleep_req && !(inv_valid && hit_request))
        |=> (parked && !wake_pulse && addr_q == $past(sleep_addr)));

    // R3
    release_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (parked && inv_valid && hit_stored) |=> (!parked && wake_pulse));

    // R5
    hold_on_foreign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (parked && !(inv_valid && hit_stored)) |=> (parked && $stable(addr_q) && !wake_pulse));

    // R7
    abort_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!parked && sleep_req && inv_valid && hit_request) |=> (!parked && wake_pulse));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> !parked);

endmodule

// File: rtl/addr_watch_sleep.sv
// Module: addr_watch_sleep (top)
// Holds one reservation slot per core and broadcasts each coherence
// invalidation to all slots, so one write releases every core on the line.
// Assumes: at most one invalidation per cycle; sleep_req is a one-cycle pulse.
module addr_watch_sleep
    import awsu_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int ADDR_W     = 32,
    parameter int LINE_OFF_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          sleep_req,
    input  logic [NUM_CORES*ADDR_W-1:0]   sleep_addr,
    input  logic                          inv_valid,
    input  logic [ADDR_W-1:0]             inv_addr,
    output logic [NUM_CORES-1:0]          core_sleep,
    output logic [NUM_CORES-1:0]          wakeup
);

    localparam int ADDR_BUS_W = NUM_CORES * ADDR_W;

    // One slot per core, all fed by the same invalidation broadcast.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
        awsu_slot #(.ADDR_W(ADDR_W), .OFF_W(LINE_OFF_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .sleep_req  (sleep_req[c]),
            .sleep_addr (sleep_addr[c*ADDR_W +: ADDR_W]),
            .inv_valid  (inv_valid),
            .inv_addr   (inv_addr),
            .parked     (core_sleep[c]),
            .wake_pulse (wakeup[c])
        );
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (core_sleep == '0 && wakeup == '0));

    // R9
    wake_needs_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_valid |=> (wakeup == '0));

    // R4
    release_keeps_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wakeup & core_sleep) == '0);

    // Bus width sanity, evaluated at start.
    initial begin
        bus_width_chk: assert ($bits(sleep_addr) == ADDR_BUS_W);
    end

endmodule

// File: tb/sim_addr_watch_sleep.sv
module sim_addr_watch_sleep;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int AW         = 32;
    localparam int OFF        = 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N-1:0]      sleep_req;
    logic [N*AW-1:0]   sleep_addr;
    logic              inv_valid;
    logic [AW-1:0]     inv_addr;
    logic [N-1:0]      core_sleep;
    logic [N-1:0]      wakeup;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    bit              m_sleep [N];
    bit              m_wake  [N];
    logic [AW-1:0]   m_addr  [N];
    logic [AW-1:0]   req_addr[N];

    addr_watch_sleep #(.NUM_CORES(N), .ADDR_W(AW), .LINE_OFF_W(OFF)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_addr(sleep_addr),
        .inv_valid(inv_valid), .inv_addr(inv_addr),
        .core_sleep(core_sleep), .wakeup(wakeup)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit same_line(input logic [AW-1:0] a, input logic [AW-1:0] b);
        return (a / (1 << OFF)) == (b / (1 << OFF));
    endfunction

    task automatic compare(input string tag);
        for (int i = 0; i < N; i++) begin
            checks++;
            if (core_sleep[i] !== m_sleep[i]) begin
                fails++;
                $display("FAIL %s core %0d core_sleep actual %b expected %b", tag, i, core_sleep[i], m_sleep[i]);
            end
            checks++;
            if (wakeup[i] !== m_wake[i]) begin
                fails++;
                $display("FAIL %s core %0d wakeup actual %b expected %b", tag, i, wakeup[i], m_wake[i]);
            end
        end
    endtask

    // Apply one cycle of stimulus at a falling edge, advance model, compare.
    task automatic step(input string tag, input logic [N-1:0] req,
                        input logic iv, input logic [AW-1:0] ia);
        sleep_req = req;
        for (int i = 0; i < N; i++) sleep_addr[i*AW +: AW] = req_addr[i];
        inv_valid = iv;
        inv_addr  = ia;
        for (int i = 0; i < N; i++) begin
            m_wake[i] = 1'b0;
            if (m_sleep[i]) begin
                if (iv && same_line(m_addr[i], ia)) begin
                    m_sleep[i] = 1'b0;
                    m_wake[i]  = 1'b1;
                end
            end else if (req[i]) begin
                if (iv && same_line(req_addr[i], ia)) m_wake[i] = 1'b1;
                else begin
                    m_sleep[i] = 1'b1;
                    m_addr[i]  = req_addr[i];
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sleep_req = '0; sleep_addr = '0; inv_valid = 1'b0; inv_addr = '0;
        for (int i = 0; i < N; i++) begin
            m_sleep[i] = 0; m_wake[i] = 0; m_addr[i] = '0; req_addr[i] = '0;
        end
        @(negedge clk);
        step("R1", '0, 1'b0, '0);
        step("R1", '0, 1'b0, '0);
        rst_n = 1'b1;

        // R2: three cores park; cores 0 and 1 share a line with different offsets
        req_addr[0] = 32'h1000_0040;
        req_addr[1] = 32'h1000_007F;
        req_addr[2] = 32'h2000_0080;
        step("R2", 4'b0111, 1'b0, '0);
        step("R2", 4'b0000, 1'b0, '0);
        // R5 R6: neighbouring line (bit 6 differs) must not release core 2
        step("R6", 4'b0000, 1'b1, 32'h2000_00C0);
        step("R5", 4'b0000, 1'b1, 32'h3000_0000);
        // R3 R4 R6: one write inside the line releases cores 0 and 1 together
        step("R4", 4'b0000, 1'b1, 32'h1000_0050);
        // R9: pulse lasts one cycle
        step("R9", 4'b0000, 1'b0, '0);
        // R7: same-cycle request and invalidation on core 3
        req_addr[3] = 32'h4000_0100;
        step("R7", 4'b1000, 1'b1, 32'h4000_0105);
        step("R7", 4'b0000, 1'b0, '0);
        // R8: request on parked core 2 with another address is ignored
        req_addr[2] = 32'h5000_0000;
        step("R8", 4'b0100, 1'b0, '0);
        step("R8", 4'b0000, 1'b1, 32'h5000_0000);
        step("R5", 4'b0000, 1'b1, 32'h2000_0088);
        step("R3", 4'b0000, 1'b0, '0);

        // Random phase over a small pool of lines to force sharing
        for (int k = 0; k < 400; k++) begin
            logic [N-1:0] r;
            for (int i = 0; i < N; i++)
                req_addr[i] = 32'h6000_0000 + (($urandom % 4) << OFF) + ($urandom % 64);
            r = N'($urandom) & N'($urandom);
            step("R4", r, ($urandom % 3) == 0,
                 32'h6000_0000 + (($urandom % 5) << OFF) + ($urandom % 64));
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule